// File: doc/BRIEF.md
# Local and Global Stall Controller

This block keeps several SIMD instruction sequencers in step when the sub-arrays they drive exchange data with neighbours that run from slightly different clocks. Each cycle, every sequencer presents the instruction it wants to issue. An instruction can read the sequencer's receive FIFOs, write a remote FIFO, or do both. The controller decides which sequencers issue in that cycle.

A sequencer whose instruction would read an empty receive FIFO, or write a remote FIFO that reports almost-full, holds at once. One cycle later it raises a registered local-stall flag. The OR of all local-stall flags passes through a configurable number of pipeline registers and becomes the global stall, which freezes every other sequencer. The other sequencers therefore run on for a few cycles after the detecting sequencer has stopped. When its blocking condition clears, the detecting sequencer first issues the instructions it owes, while the others are still frozen. Only then does the global stall drop. As a result, every instruction stream has issued the same number of instructions.

Top module: `lgstall_ctrl`

## Requirements
- R1: Each sequencer keeps a count of words waiting in its receive FIFOs. A write strobe adds one, starting with the next cycle. An issued read removes one.
- R2: If a sequencer's instruction reads and its count is zero, that sequencer does not issue in that cycle.
- R3: If a sequencer's instruction writes remotely and the remote almost-full input is high, that sequencer does not issue in that cycle.
- R4: `local_stall` of a sequencer rises the cycle after it was blocked. It stays high while the sequencer is still blocked or still owes instructions.
- R5: `global_stall` equals the OR of all `local_stall` bits, delayed by PIPE cycles. The default PIPE is 1.
- R6: A sequencer that owes nothing does not issue while `global_stall` is high. A blocked sequencer comes to owe one instruction for each cycle in which `global_stall` was low, which is PIPE+1 cycles in all.
- R7: Once unblocked, a sequencer that owes instructions issues one per cycle, even while `global_stall` is high. All streams restart together when `global_stall` falls. Between stalls, every sequencer has issued the same number of instructions.
- R8: Reset clears the counts, the owed instructions, `local_stall` and `global_stall`.
- R9: Bit k of `rx_pop` is high exactly when sequencer k issues an instruction that reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_push | input | NSEQ | Receive FIFO write strobe, one bit per sequencer |
| ins_rd | input | NSEQ | Pending instruction reads the receive FIFOs |
| ins_wr | input | NSEQ | Pending instruction writes a remote FIFO |
| tx_afull | input | NSEQ | Remote FIFO almost-full, one bit per sequencer |
| issue | output | NSEQ | Sequencer issues its pending instruction this cycle |
| rx_pop | output | NSEQ | Issued instruction reads the receive FIFOs |
| local_stall | output | NSEQ | Registered local-stall flag per sequencer |
| global_stall | output | 1 | Delayed OR of all local-stall flags |

## Verification
The bench targets the cycles between local detection and global freeze. If the local and global stall were merged, a design would stop all streams in the same cycle or let the detecting sequencer fall behind for good. It also targets the resume order: a design that released everyone at once would leave the detecting stream PIPE+1 instructions short, and the per-stream issue totals would differ. Two further cases are a write strobe in the same cycle as a read of an empty count, which must still block, and two sequencers stalling one cycle apart, each of which must repay a different number of owed instructions.

// File: rtl/lgstall_ctrl.sv
module lgstall_ctrl #(
  parameter int NSEQ = 9,
  parameter int CNTW = 4,
  parameter int PIPE = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEQ-1:0] rx_push,
  input  logic [NSEQ-1:0] ins_rd,
  input  logic [NSEQ-1:0] ins_wr,
  input  logic [NSEQ-1:0] tx_afull,
  output logic [NSEQ-1:0] issue,
  output logic [NSEQ-1:0] rx_pop,
  output logic [NSEQ-1:0] local_stall,
  output logic            global_stall
);
  localparam int DW = $clog2(PIPE + 2);

  logic [NSEQ-1:0] blocked;
  logic            g_raw;

  assign g_raw  = |local_stall;
  assign rx_pop = issue & ins_rd;

  generate
    if (PIPE == 0) begin : g_direct
      assign global_stall = g_raw;
    end else begin : g_pipe
      logic [PIPE-1:0] gp;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gp <= '0;
        else begin
          gp[0] <= g_raw;
          for (int i = 1; i < PIPE; i++) gp[i] <= gp[i-1];
        end
      end
      assign global_stall = gp[PIPE-1];
    end
  endgenerate

  generate
    for (genvar k = 0; k < NSEQ; k++) begin : g_seq
      logic [CNTW-1:0] cnt;
      logic [DW-1:0]   owe, owe_nxt;

      assign blocked[k] = (ins_rd[k] && cnt == '0) || (ins_wr[k] && tx_afull[k]);
      assign issue[k]   = !blocked[k] && (owe != '0 || !global_stall);
      assign owe_nxt    = owe + DW'(!global_stall) - DW'(issue[k]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt            <= '0;
          owe            <= '0;
          local_stall[k] <= 1'b0;
        end else begin
          cnt            <= cnt + CNTW'(rx_push[k]) - CNTW'(rx_pop[k]);
          owe            <= owe_nxt;
          local_stall[k] <= blocked[k] || owe_nxt != '0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lgstall_chk.sv
module lgstall_chk #(
  parameter int NSEQ = 9,
  parameter int PIPE = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSEQ-1:0] ins_rd,
  input logic [NSEQ-1:0] ins_wr,
  input logic [NSEQ-1:0] tx_afull,
  input logic [NSEQ-1:0] issue,
  input logic [NSEQ-1:0] rx_pop,
  input logic [NSEQ-1:0] local_stall,
  input logic            global_stall
);
  logic shadow;

  generate
    if (PIPE == 0) begin : g_sh0
      assign shadow = |local_stall;
    end else begin : g_sh
      logic [PIPE-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else begin
          sh[0] <= |local_stall;
          for (int i = 1; i < PIPE; i++) sh[i] <= sh[i-1];
        end
      end
      assign shadow = sh[PIPE-1];
    end
  endgenerate

  a_r5_global_delay: assert property (@(posedge clk) disable iff (!rst_n)
    global_stall == shadow);

  generate
    for (genvar k = 0; k < NSEQ; k++) begin : g_k
      a_r3_no_wr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue[k] && ins_wr[k] && tx_afull[k]));
      a_r4_rise_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(local_stall[k]) |-> $past(!issue[k]));
      a_r6_frozen_when_owing_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (global_stall && !local_stall[k]) |-> !issue[k]);
      a_r9_pop_implies_issue: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop[k] |-> (issue[k] && ins_rd[k]));
    end
  endgenerate
endmodule

bind lgstall_ctrl lgstall_chk #(.NSEQ(NSEQ), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_rd(ins_rd), .ins_wr(ins_wr),
  .tx_afull(tx_afull), .issue(issue), .rx_pop(rx_pop),
  .local_stall(local_stall), .global_stall(global_stall)
);

// File: tb/lgstall_ctrl_tb.sv
module lgstall_ctrl_tb;
  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] rx_push = '0, ins_rd = '0, ins_wr = '0, tx_afull = '0;
  logic [N-1:0] issue, rx_pop, local_stall;
  logic         global_stall;

  int checks = 0, fails = 0;
  int iss_cnt [N];

  always #4 clk = ~clk;

  lgstall_ctrl #(.NSEQ(N), .CNTW(4), .PIPE(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .ins_rd(ins_rd),
    .ins_wr(ins_wr), .tx_afull(tx_afull), .issue(issue), .rx_pop(rx_pop),
    .local_stall(local_stall), .global_stall(global_stall)
  );

  typedef struct packed {
    logic [8:0] push, rd, wr, af, iss, ls;
    logic       g;
    logic [3:0] req;
  } vec_t;

  // A: seq0 write blocked by almost-full (R3 R4 R5 R6 R7)
  // C: seq5 receive count, push in the same cycle as an empty read (R1 R2)
  // D: seq0 and seq8 stall one cycle apart (R6 R7)
  localparam vec_t VEC [23] = '{
    '{9'h000, 9'h000, 9'h001, 9'h001, 9'h1FE, 9'h000, 1'b0, 4'd3},
    '{9'h000, 9'h000, 9'h001, 9'h001, 9'h1FE, 9'h001, 1'b0, 4'd4},
    '{9'h000, 9'h000, 9'h001, 9'h001, 9'h000, 9'h001, 1'b1, 4'd5},
    '{9'h000, 9'h000, 9'h001, 9'h000, 9'h001, 9'h001, 1'b1, 4'd7},
    '{9'h000, 9'h000, 9'h000, 9'h000, 9'h001, 9'h001, 1'b1, 4'd7},
    '{9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 1'b1, 4'd6},
    '{9'h000, 9'h000, 9'h000, 9'h000, 9'h1FF, 9'h000, 1'b0, 4'd7},
    '{9'h020, 9'h000, 9'h000, 9'h000, 9'h1FF, 9'h000, 1'b0, 4'd1},
    '{9'h020, 9'h000, 9'h000, 9'h000, 9'h1FF, 9'h000, 1'b0, 4'd1},
    '{9'h000, 9'h020, 9'h000, 9'h000, 9'h1FF, 9'h000, 1'b0, 4'd1},
    '{9'h000, 9'h020, 9'h000, 9'h000, 9'h1FF, 9'h000, 1'b0, 4'd1},
    '{9'h000, 9'h020, 9'h000, 9'h000, 9'h1DF, 9'h000, 1'b0, 4'd2},
    '{9'h020, 9'h020, 9'h000, 9'h000, 9'h1DF, 9'h020, 1'b0, 4'd1},
    '{9'h000, 9'h020, 9'h000, 9'h000, 9'h020, 9'h020, 1'b1, 4'd7},
    '{9'h000, 9'h000, 9'h000, 9'h000, 9'h020, 9'h020, 1'b1, 4'd7},
    '{9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 1'b1, 4'd6},
    '{9'h000, 9'h000, 9'h000, 9'h000, 9'h1FF, 9'h000, 1'b0, 4'd7},
    '{9'h000, 9'h000, 9'h001, 9'h001, 9'h1FE, 9'h000, 1'b0, 4'd3},
    '{9'h000, 9'h000, 9'h101, 9'h101, 9'h0FE, 9'h001, 1'b0, 4'd6},
    '{9'h000, 9'h000, 9'h101, 9'h000, 9'h101, 9'h101, 1'b1, 4'd7},
    '{9'h000, 9'h000, 9'h000, 9'h000, 9'h001, 9'h001, 1'b1, 4'd7},
    '{9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 1'b1, 4'd5},
    '{9'h000, 9'h000, 9'h000, 9'h000, 9'h1FF, 9'h000, 1'b0, 4'd7}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tally();
    for (int k = 0; k < N; k++) if (issue[k]) iss_cnt[k]++;
  endtask

  task automatic clear_tally();
    for (int k = 0; k < N; k++) iss_cnt[k] = 0;
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    string r;
    clear_tally();
    repeat (3) @(negedge clk);
    #2;
    chk("R8", "local_stall in reset", 32'(local_stall), 32'h0);
    chk("R8", "global_stall in reset", 32'(global_stall), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R8", "local_stall after reset", 32'(local_stall), 32'h0);
    chk("R8", "issue after reset", 32'(issue), 32'h1FF);
    @(posedge clk);

    for (int i = 0; i < 23; i++) begin
      @(negedge clk);
      rx_push  = VEC[i].push;
      ins_rd   = VEC[i].rd;
      ins_wr   = VEC[i].wr;
      tx_afull = VEC[i].af;
      #2;
      r = $sformatf("R%0d", VEC[i].req);
      chk(r, $sformatf("issue v%0d", i), 32'(issue), 32'(VEC[i].iss));
      chk(r, $sformatf("local_stall v%0d", i), 32'(local_stall), 32'(VEC[i].ls));
      chk(r, $sformatf("global_stall v%0d", i), 32'(global_stall), 32'(VEC[i].g));
      chk("R9", $sformatf("rx_pop v%0d", i), 32'(rx_pop), 32'(VEC[i].iss & VEC[i].rd));
      tally();
    end

    // R7: every stream has issued 13 instructions across the three scenarios
    for (int k = 0; k < N; k++)
      chk("R7", $sformatf("issue total seq%0d", k), 32'(iss_cnt[k]), 32'd13);

    // R8: reset in the middle of a stall clears flags and owed instructions
    @(negedge clk);
    ins_wr = 9'h004; tx_afull = 9'h004;
    repeat (3) @(negedge clk);
    #2;
    chk("R4", "seq2 flag before reset", 32'(local_stall), 32'h004);
    chk("R5", "global before reset", 32'(global_stall), 32'h1);
    rst_n = 1'b0;
    #1;
    chk("R8", "flags cleared by reset", 32'(local_stall), 32'h0);
    chk("R8", "global cleared by reset", 32'(global_stall), 32'h0);
    @(negedge clk);
    ins_wr = '0; tx_afull = '0;
    rst_n = 1'b1;
    #2;
    chk("R8", "all issue after reset", 32'(issue), 32'h1FF);
    @(negedge clk);
    #2;
    chk("R8", "no residual stall", 32'(local_stall), 32'h0);
    // R2: count cleared by reset, so a read blocks at once
    ins_rd = 9'h002;
    #1;
    chk("R2", "read after reset blocks", 32'(issue), 32'h1FD);
    @(negedge clk);
    ins_rd = '0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule